// File: doc/BRIEF.md
# PCI Configuration and I/O Access Port

This block is the register-mapped port through which a host issues PCI configuration cycles and PCI I/O cycles. A single 32-bit target-address register is shared by both. The host writes the target address into it. It then reads or writes a configuration data window or an I/O data window. Each window access becomes one downstream request that carries the address, size, direction and data.

Every host access names a 4-bit byte offset inside the port and an access size of 1, 2 or 4 bytes. The block checks the size against the offset. A legal access is answered one cycle later, and if it targets a data window it raises a downstream request in that same cycle. An illegal access is answered with an error and produces no downstream request. The downstream bus cycle engine and the PCI devices sit outside the block. Read data from downstream is presented on `dn_rdata_i` in the response cycle and is passed back to the host through the data-window byte ordering.

Offset map: 0x0 is the address register, 0x4 to 0x7 is the configuration data window, 0x8 to 0xB is the I/O data window, and 0xC to 0xF is unmapped. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal. Data is right-aligned on every bus. On downstream data, byte k belongs to address+k.

Top module: `pci_cfg_io_port`

## Requirements
- R1: After reset, rsp_valid_o and dn_valid_o are low and the address register reads 0.
- R2: The address register accepts only 4-byte accesses at offset 0x0. Any other size there gets an error response and leaves the stored value unchanged. Offsets 0x1 to 0x3 are also rejected.
- R3: A read of the address register returns all 32 bits last written, including bits [1:0].
- R4: A configuration data access at offset 0x4+n (n = 0..3) issues a request with dn_io_o=0 and address {stored[31:2], n}. Bit 31 of the stored value has no effect on whether the request is issued.
- R5: An I/O data access at offset 0x8+n issues a request with dn_io_o=1. Its address is ((stored & ~3) + n) truncated to 16 bits, with the upper 16 bits zero.
- R6: The I/O window accepts sizes 1, 2 and 4 at lane 0, sizes 1 and 2 at lane 2, and size 1 only at lanes 1 and 3. Size code 3 is rejected in every window.
- R7: A rejected access returns rsp_err_o=1 and rsp_rdata_o=0, and raises no dn_valid_o.
- R8: I/O data is big-endian on the host side. A 2- or 4-byte transfer has its bytes reversed between host and downstream, in both directions.
- R9: Configuration data is not reordered. It is passed through masked to the access size, in both directions.
- R10: Each host request gets exactly one response, on the cycle after it is accepted. Any downstream request is raised in that same cycle.
- R11: Accesses to offsets 0xC to 0xF are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 4 | Byte offset inside the port |
| req_size_i | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:illegal) |
| req_wdata_i | input | 32 | Host write data, right-aligned |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 32 | Host read data, right-aligned |
| dn_valid_o | output | 1 | Downstream request strobe |
| dn_io_o | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| dn_write_o | output | 1 | Downstream direction |
| dn_addr_o | output | 32 | Downstream address |
| dn_size_o | output | 2 | Downstream size code |
| dn_wdata_o | output | 32 | Downstream write data, byte k at address+k |
| dn_rdata_i | input | 32 | Downstream read data in the response cycle |

## Verification
The bench walks the I/O window across every lane and size pair. A decoder that is too permissive would forward a 2-byte access at an odd lane, and one that is too strict would reject a 2-byte access at lane 2. It loads an address with bit 31 set and low bits nonzero. A design that gated on the top bit would drop configuration requests, and one that forwarded the raw low bits would skew both the configuration and I/O addresses, while the readback must still show those bits. I/O and configuration transfers of 2 and 4 bytes are compared in both directions, which exposes a missing or misapplied byte swap. An address above 16 bits checks I/O truncation. A non-word write to the address register must leave its contents intact.

// File: rtl/pci_port_pkg.sv
package pci_port_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned IO_AW  = 16;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_X = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    RG_ADDR = 2'd0,
    RG_CFG  = 2'd1,
    RG_IO   = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/pci_port_decode.sv
module pci_port_decode
  import pci_port_pkg::*;
#(
  parameter int unsigned OW = OFF_W
) (
  input  logic [OW-1:0] off_i,
  input  logic [1:0]    size_i,
  output logic          hit_reg_o,
  output logic          hit_cfg_o,
  output logic          hit_io_o,
  output logic          legal_o
);
  logic [1:0] lane;
  region_e    rg;

  assign lane = off_i[1:0];
  assign rg   = region_e'(off_i[3:2]);

  always_comb begin
    hit_reg_o = 1'b0;
    hit_cfg_o = 1'b0;
    hit_io_o  = 1'b0;
    legal_o   = 1'b0;
    unique case (rg)
      RG_ADDR: begin
        hit_reg_o = 1'b1;
        legal_o   = (lane == 2'd0) && (size_i == SZ_W);
      end
      RG_CFG: begin
        hit_cfg_o = 1'b1;
        legal_o   = (size_i != SZ_X);
      end
      RG_IO: begin
        hit_io_o = 1'b1;
        unique case (lane)
          2'd0:    legal_o = (size_i != SZ_X);
          2'd2:    legal_o = (size_i == SZ_B) || (size_i == SZ_H);
          default: legal_o = (size_i == SZ_B);
        endcase
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_addr_store.sv
module pci_addr_store
  import pci_port_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] full_o,
  output logic [DW-1:0] fwd_o
);
  logic [DW-1:0] full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      full_q <= '0;
    else if (wr_en_i) full_q <= wdata_i;
  end

  assign full_o = full_q;
  assign fwd_o  = {full_q[DW-1:2], 2'b00};

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(full_q));
endmodule

// File: rtl/pci_lane_order.sv
module pci_lane_order
  import pci_port_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    size_i,
  input  logic          swap_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] rev_w;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev_w[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
  end

  always_comb begin
    data_o = '0;
    unique case (size_i)
      SZ_B: data_o[7:0]  = data_i[7:0];
      SZ_H: data_o[15:0] = swap_i ? {data_i[7:0], data_i[15:8]} : data_i[15:0];
      SZ_W: data_o       = swap_i ? rev_w : data_i;
      default: data_o    = '0;
    endcase
  end
endmodule

// File: rtl/pci_cfg_io_port.sv
module pci_cfg_io_port
  import pci_port_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W,
  parameter int unsigned AW = IO_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [OW-1:0] req_off_i,
  input  logic [1:0]    req_size_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          dn_valid_o,
  output logic          dn_io_o,
  output logic          dn_write_o,
  output logic [DW-1:0] dn_addr_o,
  output logic [1:0]    dn_size_o,
  output logic [DW-1:0] dn_wdata_o,
  input  logic [DW-1:0] dn_rdata_i
);
  logic          hit_reg, hit_cfg, hit_io, legal;
  logic          reg_wr;
  logic [DW-1:0] addr_full, addr_fwd;
  logic [DW-1:0] wdata_ord, rdata_ord;
  logic [AW-1:0] io_addr;
  logic [DW-1:0] dn_addr_d;
  logic          dn_go;

  logic          rsp_valid_q, rsp_err_q, reg_rd_q;
  logic [DW-1:0] reg_rdata_q;
  logic          dn_valid_q, dn_io_q, dn_write_q;
  logic [DW-1:0] dn_addr_q, dn_wdata_q;
  logic [1:0]    dn_size_q;

  pci_port_decode #(.OW(OW)) u_dec (
    .off_i     (req_off_i),
    .size_i    (req_size_i),
    .hit_reg_o (hit_reg),
    .hit_cfg_o (hit_cfg),
    .hit_io_o  (hit_io),
    .legal_o   (legal)
  );

  assign reg_wr = req_valid_i && hit_reg && legal && req_write_i;

  pci_addr_store #(.DW(DW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (reg_wr),
    .wdata_i (req_wdata_i),
    .full_o  (addr_full),
    .fwd_o   (addr_fwd)
  );

  pci_lane_order #(.DW(DW)) u_word (
    .data_i (req_wdata_i),
    .size_i (req_size_i),
    .swap_i (hit_io),
    .data_o (wdata_ord)
  );

  pci_lane_order #(.DW(DW)) u_rord (
    .data_i (dn_rdata_i),
    .size_i (dn_size_q),
    .swap_i (dn_io_q),
    .data_o (rdata_ord)
  );

  assign io_addr = addr_fwd[AW-1:0] + AW'(req_off_i[1:0]);
  assign dn_go   = req_valid_i && legal && (hit_cfg || hit_io);

  always_comb begin
    if (hit_io) dn_addr_d = {{(DW-AW){1'b0}}, io_addr};
    else        dn_addr_d = {addr_fwd[DW-1:2], req_off_i[1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      reg_rd_q    <= 1'b0;
      reg_rdata_q <= '0;
      dn_valid_q  <= 1'b0;
      dn_io_q     <= 1'b0;
      dn_write_q  <= 1'b0;
      dn_addr_q   <= '0;
      dn_size_q   <= SZ_B;
      dn_wdata_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i && !legal;
      reg_rd_q    <= req_valid_i && hit_reg && legal && !req_write_i;
      reg_rdata_q <= addr_full;
      dn_valid_q  <= dn_go;
      if (dn_go) begin
        dn_io_q    <= hit_io;
        dn_write_q <= req_write_i;
        dn_addr_q  <= dn_addr_d;
        dn_size_q  <= req_size_i;
        dn_wdata_q <= req_write_i ? wdata_ord : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign dn_valid_o  = dn_valid_q;
  assign dn_io_o     = dn_io_q;
  assign dn_write_o  = dn_write_q;
  assign dn_addr_o   = dn_addr_q;
  assign dn_size_o   = dn_size_q;
  assign dn_wdata_o  = dn_wdata_q;

  always_comb begin
    if (!rsp_valid_q || rsp_err_q)     rsp_rdata_o = '0;
    else if (reg_rd_q)                 rsp_rdata_o = reg_rdata_q;
    else if (dn_valid_q && !dn_write_q) rsp_rdata_o = rdata_ord;
    else                               rsp_rdata_o = '0;
  end

  a_r10_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r10_dn_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> rsp_valid_o);
  a_r7_err_no_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (!dn_valid_o && rsp_rdata_o == '0));
  a_r5_io_addr_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && dn_io_o) |-> (dn_addr_o[DW-1:AW] == '0));
  a_r6_odd_lane_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && dn_io_o && dn_addr_o[0]) |-> (dn_size_o == SZ_B));
endmodule

// File: tb/pci_cfg_io_port_tb_top.sv
module pci_cfg_io_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, dn_valid, dn_io, dn_write;
  logic [31:0] rsp_rdata, dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_cfg_io_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_off_i(req_off),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .dn_valid_o(dn_valid), .dn_io_o(dn_io), .dn_write_o(dn_write),
    .dn_addr_o(dn_addr), .dn_size_o(dn_size), .dn_wdata_o(dn_wdata),
    .dn_rdata_i(dn_rdata)
  );

  typedef struct packed {
    logic [3:0]  off;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        err;
    logic        io;
    logic [31:0] addr;
    logic [31:0] dwd;
  } vec_t;

  // address register holds 32'h8000_1236 while the table runs
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'h4, 2'd1, 32'h0000_AABB, 1'b0, 1'b0, 32'h8000_1234, 32'h0000_AABB},
    '{4'h7, 2'd0, 32'h0000_0055, 1'b0, 1'b0, 32'h8000_1237, 32'h0000_0055},
    '{4'h8, 2'd2, 32'h1122_3344, 1'b0, 1'b1, 32'h0000_1234, 32'h4433_2211},
    '{4'h8, 2'd1, 32'h0000_AABB, 1'b0, 1'b1, 32'h0000_1234, 32'h0000_BBAA},
    '{4'h9, 2'd0, 32'h0000_007F, 1'b0, 1'b1, 32'h0000_1235, 32'h0000_007F},
    '{4'h9, 2'd1, 32'h0000_1111, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'hA, 2'd1, 32'h0000_CAFE, 1'b0, 1'b1, 32'h0000_1236, 32'h0000_FECA},
    '{4'hA, 2'd2, 32'h1234_5678, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'hB, 2'd0, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_1237, 32'h0000_0001},
    '{4'hB, 2'd1, 32'h0000_0101, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'h8, 2'd3, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'hC, 2'd2, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'h1, 2'd2, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         32'h0},
    '{4'h4, 2'd3, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access at a falling edge; sample at the next falling edge
  task automatic access(input logic wr, input logic [3:0] off, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_off = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 dn_valid after reset", 32'(dn_valid), 32'd0);
    rst_n = 1'b1;
    access(1'b0, 4'h0, 2'd2, 32'h0);
    check("R1 addr reg reset value", rsp_rdata, 32'h0);

    access(1'b1, 4'h0, 2'd2, 32'h8000_1236);
    check("R10 rsp after addr write", 32'({rsp_valid, rsp_err, dn_valid}), 32'b100);
    access(1'b0, 4'h0, 2'd2, 32'h0);
    check("R3 addr readback keeps low bits", rsp_rdata, 32'h8000_1236);

    access(1'b1, 4'h0, 2'd1, 32'h0000_FFFF);
    check("R2 half write to addr reg errors", 32'({rsp_valid, rsp_err}), 32'b11);
    access(1'b0, 4'h0, 2'd2, 32'h0);
    check("R2 addr reg unchanged", rsp_rdata, 32'h8000_1236);

    for (int i = 0; i < NV; i++) begin
      access(1'b1, VECS[i].off, VECS[i].size, VECS[i].wdata);
      check($sformatf("R10 vec%0d rsp_valid", i), 32'(rsp_valid), 32'd1);
      check($sformatf("R6/R7/R11 vec%0d err", i), 32'(rsp_err), 32'(VECS[i].err));
      check($sformatf("R7 vec%0d dn_valid", i), 32'(dn_valid), 32'(!VECS[i].err));
      if (!VECS[i].err) begin
        check($sformatf("R4/R5 vec%0d kind", i), 32'(dn_io), 32'(VECS[i].io));
        check($sformatf("R4/R5 vec%0d addr", i), dn_addr, VECS[i].addr);
        check($sformatf("R8/R9 vec%0d wdata", i), dn_wdata, VECS[i].dwd);
        check($sformatf("R10 vec%0d size", i), 32'(dn_size), 32'(VECS[i].size));
      end
    end

    dn_rdata = 32'h1122_3344;
    access(1'b0, 4'h8, 2'd2, 32'h0);
    check("R8 io word read reversed", rsp_rdata, 32'h4433_2211);
    check("R8 io read direction", 32'(dn_write), 32'd0);
    access(1'b0, 4'h4, 2'd2, 32'h0);
    check("R9 cfg word read unchanged", rsp_rdata, 32'h1122_3344);
    dn_rdata = 32'h7777_BBAA;
    access(1'b0, 4'hA, 2'd1, 32'h0);
    check("R8 io half read swapped", rsp_rdata, 32'h0000_AABB);
    access(1'b0, 4'h6, 2'd1, 32'h0);
    check("R9 cfg half read masked", rsp_rdata, 32'h0000_BBAA);
    check("R4 cfg read addr", dn_addr, 32'h8000_1236);
    access(1'b0, 4'hD, 2'd0, 32'h0);
    check("R7 err read data zero", rsp_rdata, 32'h0);

    access(1'b1, 4'h0, 2'd2, 32'h0003_0007);
    access(1'b1, 4'h9, 2'd0, 32'h0000_00AB);
    check("R5 io addr truncated", dn_addr, 32'h0000_0005);
    access(1'b1, 4'h5, 2'd0, 32'h0000_00CD);
    check("R4 cfg addr low bits from offset", dn_addr, 32'h0003_0005);

    @(negedge clk);
    check("R10 idle no rsp", 32'({rsp_valid, dn_valid}), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule